// File: doc/BRIEF.md
# Memory Attribute Remap Unit

This block turns the three-bit page-table attribute index {TEX[0],C,B} and the page's shareable bit into a final memory type, a shareability flag and separate inner and outer cacheability codes. Two 32-bit remap registers drive the lookup. The first is a type register: it holds one 2-bit memory type per index, plus four shareability bits. The second is a cacheability register: it holds one inner and one outer 2-bit code per index. A full copy of both registers exists for the secure world and another for the non-secure world.

Software reaches the registers through a simple register port. That port carries the privilege level and security state of the access, and a lock input that blocks secure writes. The lookup path is purely combinational. It picks the register copy that matches the security state of the translated access. When its remap-enable input is low, it falls back to the reset mapping, so the attributes pass through with their default meaning.

Top module: `attr_remap_unit`

## Requirements
- R1: After reset, both banks read 0x00098AA4 from the type register (`regSel`=0) and 0x44E048E0 from the cacheability register (`regSel`=1).
- R2: A privileged write is accepted when it is not blocked by R4. It updates the register chosen by `regSel` in the bank chosen by `regSecure`, and takes effect from the next clock. Type-register bits [31:20] always read as zero.
- R3: An unprivileged write (`regPriv`=0) changes no register. An unprivileged read, or a read with `regRdEn`=0, returns zero.
- R4: A privileged secure write while `secWrLock`=1 raises `regUndef` in the same cycle and leaves every register unchanged. A non-secure write under the same lock is accepted, and `regUndef` stays low.
- R5: Each security bank is written only by accesses of its own state. The lookup uses the bank selected by `lkSecure` (1 = secure).
- R6: With remap enabled, `lkMemType` is bits [2i+1:2i] of the type register, where i = {lkTex0,lkC,lkB}. The encodings are 00 strongly ordered, 01 device and 10 normal. A stored 11 is reported as 10.
- R7: For a normal result, `lkShared` is type-register bit 19 when `lkShare`=1 and bit 18 when `lkShare`=0. For a device result, it is bit 17 or bit 16 in the same way. A strongly ordered result is always shared.
- R8: For a normal result, `lkInner` is cacheability-register bits [2i+1:2i] and `lkOuter` is bits [2i+17:2i+16]. The codes are 00 non-cacheable, 01 write-back with write allocate, 10 write-through, and 11 write-back without write allocate. Any other result type gives 00 for both.
- R9: With `lkRemapEn`=0, the lookup ignores the registers and applies R6 to R8 to the reset values of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write request |
| regRdEn | input | 1 | Register read request |
| regSel | input | 1 | 0 = type register, 1 = cacheability register |
| regSecure | input | 1 | Security state of the register access |
| regPriv | input | 1 | Access is privileged |
| secWrLock | input | 1 | Blocks secure writes |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data (combinational) |
| regUndef | output | 1 | Blocked secure write, undefined-instruction indication |
| lkSecure | input | 1 | Security state of the translated access |
| lkRemapEn | input | 1 | Remap enable |
| lkTex0 | input | 1 | Index bit 2 |
| lkC | input | 1 | Index bit 1 |
| lkB | input | 1 | Index bit 0 |
| lkShare | input | 1 | Shareable bit from the page table |
| lkMemType | output | 2 | Final memory type |
| lkShared | output | 1 | Final shareability |
| lkInner | output | 2 | Inner cacheability |
| lkOuter | output | 2 | Outer cacheability |

## Verification
The assertions assume that `rstN` is held low for at least one clock edge. They also assume that every register-port and lookup input is stable around the rising edge, because reads, lookups and `regUndef` are sampled as combinational values of those inputs. The bench changes every input only just after the falling edge and compares it shortly afterwards, well before the next rising edge. The random phase mixes privilege, lock and security values freely, because the design must tolerate any combination of them. It also writes arbitrary data, including the reserved type code 11.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int REG_W      = 32;
  localparam int IDX_W      = 3;
  localparam int FIELD_W    = 2;
  localparam int NUM_BANKS  = 2;
  localparam int BANK_W     = $clog2(NUM_BANKS);
  localparam int PRIM_LIVE  = 20;
  localparam int OUTER_BASE = REG_W / 2;
  localparam int SH_NORM_1  = 19;
  localparam int SH_NORM_0  = 18;
  localparam int SH_DEV_1   = 17;
  localparam int SH_DEV_0   = 16;
  localparam logic [REG_W-1:0] PRIM_MASK = REG_W'((64'd1 << PRIM_LIVE) - 64'd1);

  typedef enum logic [FIELD_W-1:0] {
    MT_SO   = 2'b00,
    MT_DEV  = 2'b01,
    MT_NORM = 2'b10,
    MT_RSVD = 2'b11
  } mem_type_e;

  typedef struct packed {
    logic              wrPrim;
    logic              wrNorm;
    logic              rdValid;
    logic              sel;
    logic [BANK_W-1:0] bank;
  } remap_strobe_t;
endpackage

// File: rtl/remap_ctrl.sv
module remap_ctrl
  import remap_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic          regRdEn,
  input  logic          regSel,
  input  logic          regSecure,
  input  logic          regPriv,
  input  logic          secWrLock,
  output remap_strobe_t strb,
  output logic          regUndef
);
  logic privWr;
  logic blocked;

  always_comb begin
    privWr       = regWrEn && regPriv;
    blocked      = privWr && regSecure && secWrLock;
    regUndef     = blocked;
    strb.wrPrim  = privWr && !blocked && !regSel;
    strb.wrNorm  = privWr && !blocked && regSel;
    strb.rdValid = regRdEn && regPriv;
    strb.sel     = regSel;
    strb.bank    = BANK_W'(regSecure);
  end

  assert_undef_blocks_R4: assert property (@(posedge clk) disable iff (!rstN)
    regUndef |-> (regSecure && secWrLock && !strb.wrPrim && !strb.wrNorm));

  assert_unpriv_inert_R3: assert property (@(posedge clk) disable iff (!rstN)
    !regPriv |-> (!strb.wrPrim && !strb.wrNorm && !strb.rdValid && !regUndef));
endmodule

// File: rtl/remap_datapath.sv
module remap_datapath
  import remap_pkg::*;
#(
  parameter logic [REG_W-1:0] PRIM_RESET = 32'h00098AA4,
  parameter logic [REG_W-1:0] NORM_RESET = 32'h44E048E0
) (
  input  logic               clk,
  input  logic               rstN,
  input  remap_strobe_t      strb,
  input  logic [REG_W-1:0]   wrData,
  output logic [REG_W-1:0]   rdData,
  input  logic               lkSecure,
  input  logic               lkRemapEn,
  input  logic [IDX_W-1:0]   lkIdx,
  input  logic               lkShare,
  output logic [FIELD_W-1:0] lkMemType,
  output logic               lkShared,
  output logic [FIELD_W-1:0] lkInner,
  output logic [FIELD_W-1:0] lkOuter
);
  logic [NUM_BANKS-1:0][REG_W-1:0] primReg;
  logic [NUM_BANKS-1:0][REG_W-1:0] normReg;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN) begin
        primReg[b] <= PRIM_RESET & PRIM_MASK;
        normReg[b] <= NORM_RESET;
      end else begin
        if (strb.wrPrim && (strb.bank == BANK_W'(b))) primReg[b] <= wrData & PRIM_MASK;
        if (strb.wrNorm && (strb.bank == BANK_W'(b))) normReg[b] <= wrData;
      end
    end
  end

  always_comb begin
    if (!strb.rdValid)  rdData = '0;
    else if (strb.sel)  rdData = normReg[strb.bank];
    else                rdData = primReg[strb.bank];
  end

  logic [REG_W-1:0]   primSrc;
  logic [REG_W-1:0]   normSrc;
  logic [FIELD_W-1:0] rawType;
  mem_type_e          finalType;

  always_comb begin
    primSrc   = lkRemapEn ? primReg[BANK_W'(lkSecure)] : (PRIM_RESET & PRIM_MASK);
    normSrc   = lkRemapEn ? normReg[BANK_W'(lkSecure)] : NORM_RESET;
    rawType   = primSrc[{lkIdx, 1'b0} +: FIELD_W];
    finalType = (mem_type_e'(rawType) == MT_RSVD) ? MT_NORM : mem_type_e'(rawType);
    lkMemType = finalType;
    lkInner   = '0;
    lkOuter   = '0;
    unique case (finalType)
      MT_NORM: begin
        lkShared = lkShare ? primSrc[SH_NORM_1] : primSrc[SH_NORM_0];
        lkInner  = normSrc[{lkIdx, 1'b0} +: FIELD_W];
        lkOuter  = normSrc[OUTER_BASE + {lkIdx, 1'b0} +: FIELD_W];
      end
      MT_DEV:  lkShared = lkShare ? primSrc[SH_DEV_1] : primSrc[SH_DEV_0];
      default: lkShared = 1'b1;
    endcase
  end

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (primReg[0][REG_W-1:PRIM_LIVE] == '0) && (primReg[1][REG_W-1:PRIM_LIVE] == '0));

  assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrPrim && !strb.wrNorm) |=> ($stable(primReg) && $stable(normReg)));

  assert_type_legal_R6: assert property (@(posedge clk) disable iff (!rstN)
    lkMemType != MT_RSVD);

  assert_so_shared_R7: assert property (@(posedge clk) disable iff (!rstN)
    (lkMemType == MT_SO) |-> lkShared);

  assert_nonnormal_uncached_R8: assert property (@(posedge clk) disable iff (!rstN)
    (lkMemType != MT_NORM) |-> (lkInner == '0 && lkOuter == '0));

  assert_bypass_index0_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!lkRemapEn && lkIdx == '0) |-> (lkMemType == PRIM_RESET[1:0] || lkMemType == MT_NORM));
endmodule

// File: rtl/attr_remap_unit.sv
module attr_remap_unit
  import remap_pkg::*;
#(
  parameter logic [31:0] PRIM_RESET = 32'h00098AA4,
  parameter logic [31:0] NORM_RESET = 32'h44E048E0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic        regSel,
  input  logic        regSecure,
  input  logic        regPriv,
  input  logic        secWrLock,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        regUndef,
  input  logic        lkSecure,
  input  logic        lkRemapEn,
  input  logic        lkTex0,
  input  logic        lkC,
  input  logic        lkB,
  input  logic        lkShare,
  output logic [1:0]  lkMemType,
  output logic        lkShared,
  output logic [1:0]  lkInner,
  output logic [1:0]  lkOuter
);
  remap_strobe_t strb;

  remap_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regSel    (regSel),
    .regSecure (regSecure),
    .regPriv   (regPriv),
    .secWrLock (secWrLock),
    .strb      (strb),
    .regUndef  (regUndef)
  );

  remap_datapath #(
    .PRIM_RESET (PRIM_RESET),
    .NORM_RESET (NORM_RESET)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (regWrData),
    .rdData    (regRdData),
    .lkSecure  (lkSecure),
    .lkRemapEn (lkRemapEn),
    .lkIdx     ({lkTex0, lkC, lkB}),
    .lkShare   (lkShare),
    .lkMemType (lkMemType),
    .lkShared  (lkShared),
    .lkInner   (lkInner),
    .lkOuter   (lkOuter)
  );

  assert_unpriv_read_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!regPriv || !regRdEn) |-> (regRdData == 32'h0));
endmodule

// File: tb/sim_attr_remap_unit.sv
`timescale 1ns/1ps
module sim_attr_remap_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 0, regRdEn = 0, regSel = 0, regSecure = 0, regPriv = 0, secWrLock = 0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic regUndef;
  logic lkSecure = 0, lkRemapEn = 0, lkTex0 = 0, lkC = 0, lkB = 0, lkShare = 0;
  logic [1:0] lkMemType, lkInner, lkOuter;
  logic lkShared;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  localparam logic [31:0] PRIM_DEF = 32'h00098AA4;
  localparam logic [31:0] NORM_DEF = 32'h44E048E0;

  // reference state: [bank] with 1 = secure
  logic [31:0] mPrim [2];
  logic [31:0] mNorm [2];

  always #10 clk = ~clk;

  attr_remap_unit u0 (.*);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive after the falling edge, compare, then commit the model
  task automatic step(input bit wr, input bit rd, input bit sel, input bit sec, input bit priv,
                      input bit lock, input logic [31:0] data, input bit lsec, input bit en,
                      input int idx, input bit sh, input string rdTag);
    int prim, norm, ty, expSh, expIn, expOut, expRd;
    bit expUndef;
    @(negedge clk);
    regWrEn = wr; regRdEn = rd; regSel = sel; regSecure = sec; regPriv = priv;
    secWrLock = lock; regWrData = data; lkSecure = lsec; lkRemapEn = en;
    lkTex0 = idx[2]; lkC = idx[1]; lkB = idx[0]; lkShare = sh;
    #2;
    expRd = (rd && priv) ? (sel ? mNorm[sec] : mPrim[sec]) : 0;
    chk(rdTag, "regRdData", regRdData, expRd);
    expUndef = wr && priv && sec && lock;
    chk("R4", "regUndef", regUndef, expUndef);
    prim = en ? mPrim[lsec] : PRIM_DEF;
    norm = en ? mNorm[lsec] : NORM_DEF;
    ty = (prim >> (2 * idx)) & 3;
    if (ty == 3) ty = 2;
    if (ty == 2)      expSh = sh ? ((prim >> 19) & 1) : ((prim >> 18) & 1);
    else if (ty == 1) expSh = sh ? ((prim >> 17) & 1) : ((prim >> 16) & 1);
    else              expSh = 1;
    expIn  = (ty == 2) ? ((norm >> (2 * idx)) & 3) : 0;
    expOut = (ty == 2) ? ((norm >> (16 + 2 * idx)) & 3) : 0;
    chk(en ? "R6" : "R9", "lkMemType", lkMemType, ty);
    chk(en ? "R7" : "R9", "lkShared", lkShared, expSh);
    chk(en ? "R8" : "R9", "lkInner", lkInner, expIn);
    chk(en ? "R8" : "R9", "lkOuter", lkOuter, expOut);
    if (wr && priv && !(sec && lock)) begin
      if (sel) mNorm[sec] = data;
      else     mPrim[sec] = data & 32'h000FFFFF;
    end
  endtask

  task automatic rdReg(input bit sel, input bit sec, input string tag);
    step(0, 1, sel, sec, 1, 0, 32'h0, 0, 1, 0, 0, tag);
  endtask

  initial begin
    mPrim[0] = PRIM_DEF; mPrim[1] = PRIM_DEF;
    mNorm[0] = NORM_DEF; mNorm[1] = NORM_DEF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values in both banks
    for (int s = 0; s < 2; s++) begin
      rdReg(0, s[0], "R1");
      rdReg(1, s[0], "R1");
    end
    // R9 index sweep at reset with remap on and off
    for (int i = 0; i < 8; i++) begin
      step(0, 0, 0, 0, 1, 0, 0, 0, 1, i, i[0], "R1");
      step(0, 0, 0, 0, 1, 0, 0, 1, 0, i, ~i[0], "R9");
    end
    // R2 write all ones to secure type register, upper bits dropped
    step(1, 0, 0, 1, 1, 0, 32'hFFFFFFFF, 0, 1, 0, 0, "R2");
    rdReg(0, 1, "R2");
    chk("R2", "upper bits zero", int'(regRdData[31:20]), 0);
    // R3 unprivileged write ignored, unprivileged read zero
    step(1, 1, 0, 0, 0, 0, 32'h12345678, 0, 1, 0, 0, "R3");
    rdReg(0, 0, "R3");
    step(0, 1, 1, 1, 0, 0, 0, 1, 1, 3, 1, "R3");
    // R4 secure write blocked by lock, non-secure accepted
    step(1, 0, 1, 1, 1, 1, 32'hAAAA5555, 1, 1, 2, 1, "R4");
    rdReg(1, 1, "R4");
    step(1, 0, 1, 0, 1, 1, 32'h5555AAAA, 0, 1, 2, 1, "R4");
    rdReg(1, 0, "R4");
    // R6 reserved code 11 at index 5, R5 bank-selected lookups
    step(1, 0, 0, 0, 1, 0, 32'h000D0C00, 0, 1, 0, 0, "R6");
    for (int i = 0; i < 8; i++) begin
      step(0, 0, 0, 0, 1, 0, 0, 0, 1, i, 1, "R5");
      step(0, 0, 0, 0, 1, 0, 0, 1, 1, i, 0, "R5");
      step(0, 0, 0, 0, 1, 0, 0, 0, 0, i, 1, "R9");
    end
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0], r[1], r[2], r[3], r[4] | r[5], r[6] & r[7], $urandom, r[8], r[9] | r[10],
           int'(r[13:11]), r[14], "R5");
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule